// File: doc/BRIEF.md
# Load-Balancing Neuron Dispatcher

This block sits between a stream of dendrite potentials, ordered by neuron address, and two processing elements that compute membrane potentials. Every incoming potential carries the index of the neuron it belongs to, the layer that neuron sits in, its data word and a marker that flags the final potential of the neuron. The dispatcher gathers one neuron at a time in a small local buffer. It then pushes the whole group into one of two processing-element FIFOs, so a neuron is never split between the two elements.

Two decisions are made once per neuron. The first is pruning. Each potential is typed through a per-layer program table that is indexed by the potential's position inside the neuron. A neuron with no additive potential can never fire, so its multiplicative and subtractive potentials are dropped without being dispatched. The second is the choice of target. It is taken from the two FIFOs' half-full flags: the less loaded element is preferred, and a toggle breaks ties. The FIFO full flags apply back-pressure to the stream without losing or reordering entries.

Top module: `neuron_dispatcher`

## Requirements
- R1: Each dispatched entry is pushed to exactly one FIFO. An entry is never pushed while that FIFO's full flag is high. While the flag stays high, dispatch waits and the entry stays pending.
- R2: All kept entries of one neuron go to the same FIFO, in arrival order, with their data and neuron index unchanged. `out_last` is high only on the final entry.
- R3: When exactly one half-full flag is low, the neuron goes to that FIFO. Bit 0 of `fifo_half` and `fifo_full` belongs to element 0, and bit 1 to element 1.
- R4: When both half-full flags are equal, targets alternate between the two elements, starting with element 0 after reset. A neuron that goes to the element with the low half-full flag does not change the toggle.
- R5: The type of the potential at position p (0 = first) of a neuron in layer L is the 2-bit field at bit (L*DEPTH+p)*2 of `type_prog`, and it is driven on `out_type`. Code 00 means additive, 01 means multiplicative, and 10 and 11 mean subtractive.
- R6: A neuron with no additive potential produces no push at all. `in_ready` is high again in the cycle right after its closing entry is accepted.
- R7: A neuron closes when an entry with `in_last` high is accepted, or when its DEPTH-th entry is accepted, whichever comes first.
- R8: After a kept neuron closes, `in_ready` is low from the next cycle until its final entry has been pushed. No push happens while `in_ready` is high.
- R9: After reset, `in_ready` is high and `out_push` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| type_prog | input | LAYERS*DEPTH*2 | Per-layer, per-position type codes |
| in_valid | input | 1 | Potential present on the input |
| in_ready | output | 1 | Dispatcher accepts a potential |
| in_nidx | input | NIDX_W | Neuron index |
| in_layer | input | clog2(LAYERS) | Layer of the neuron |
| in_data | input | DATA_W | Potential value |
| in_last | input | 1 | Final potential of the neuron |
| fifo_half | input | 2 | Half-full flag of each element FIFO |
| fifo_full | input | 2 | Full flag of each element FIFO |
| out_push | output | 2 | Write strobe per element FIFO |
| out_nidx | output | NIDX_W | Neuron index of pushed entry |
| out_data | output | DATA_W | Potential value of pushed entry |
| out_type | output | 2 | Type code of pushed entry |
| out_last | output | 1 | Pushed entry closes the neuron |

## Verification
Two things can meet in the same cycle: the choice of a target from the half-full flags and the back-pressure from the full flags. At the moment a neuron is assigned, the full flag of the chosen element may already be high. The bench sets the half-full pattern of each neuron (ties, one element loaded, both loaded) and toggles both full flags at random on every cycle, so a stalled first push often coincides with the target decision. It then judges that the neuron still lands whole, in order, on the element predicted by the selection rule and the bench's own model of the tie toggle, and that no push happens against a raised full flag.

// File: rtl/dn_pkg.sv
package dn_pkg;
  localparam int NUM_PE = 2;

  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_ASSIGN = 2'd1,
    ST_EMIT   = 2'd2
  } dn_state_e;

  localparam logic [1:0] CODE_ADD = 2'b00;
endpackage

// File: rtl/dn_type_lookup.sv
module dn_type_lookup #(
  parameter int LAYERS = 4,
  parameter int DEPTH  = 8,
  localparam int LAYER_W = $clog2(LAYERS),
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic [LAYERS*DEPTH*2-1:0] prog,
  input  logic [LAYER_W-1:0]        layer,
  input  logic [PTR_W-1:0]          pos,
  output logic [1:0]                code,
  output logic                      is_add
);
  import dn_pkg::*;

  always_comb begin
    int slot;
    slot = int'(layer) * DEPTH + int'(pos);
    code = 2'b11;
    if (slot < LAYERS * DEPTH) code = prog[slot*2 +: 2];
    is_add = (code == CODE_ADD);
  end
endmodule

// File: rtl/dn_pe_select.sv
module dn_pe_select (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       decide,
  input  logic [1:0] half,
  output logic       target
);
  logic target_q, target_d;
  logic alt_q, alt_d;

  always_comb begin
    target_d = target_q;
    alt_d    = alt_q;
    if (decide) begin
      if (half[0] != half[1]) begin
        target_d = half[0];
      end else begin
        target_d = alt_q;
        alt_d    = ~alt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= 1'b0;
      alt_q    <= 1'b0;
    end else if (decide) begin
      target_q <= target_d;
      alt_q    <= alt_d;
    end
  end

  assign target = target_q;
endmodule

// File: rtl/dn_neuron_buffer.sv
module dn_neuron_buffer #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_code,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_code
);
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [1:0]        code_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_ptr] <= wr_data;
      code_mem[wr_ptr] <= wr_code;
    end
  end

  assign rd_data = data_mem[rd_ptr];
  assign rd_code = code_mem[rd_ptr];
endmodule

// File: rtl/neuron_dispatcher.sv
module neuron_dispatcher #(
  parameter int DATA_W = 16,
  parameter int NIDX_W = 12,
  parameter int LAYERS = 4,
  parameter int DEPTH  = 8,
  localparam int LAYER_W = $clog2(LAYERS),
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LAYERS*DEPTH*2-1:0] type_prog,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NIDX_W-1:0]         in_nidx,
  input  logic [LAYER_W-1:0]        in_layer,
  input  logic [DATA_W-1:0]         in_data,
  input  logic                      in_last,
  input  logic [1:0]                fifo_half,
  input  logic [1:0]                fifo_full,
  output logic [1:0]                out_push,
  output logic [NIDX_W-1:0]         out_nidx,
  output logic [DATA_W-1:0]         out_data,
  output logic [1:0]                out_type,
  output logic                      out_last
);
  import dn_pkg::*;

  dn_state_e         state_q, state_d;
  logic [PTR_W-1:0]  wpos_q, wpos_d;
  logic [PTR_W-1:0]  rpos_q, rpos_d;
  logic [PTR_W-1:0]  end_q, end_d;
  logic              add_q, add_d;
  logic [NIDX_W-1:0] nidx_q, nidx_d;

  logic [1:0] cur_code;
  logic       cur_add;
  logic       accept, closing, keep, decide, target, emit;

  dn_type_lookup #(.LAYERS(LAYERS), .DEPTH(DEPTH)) u_lookup (
    .prog   (type_prog),
    .layer  (in_layer),
    .pos    (wpos_q),
    .code   (cur_code),
    .is_add (cur_add)
  );

  dn_neuron_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .wr_en   (accept),
    .wr_ptr  (wpos_q),
    .wr_data (in_data),
    .wr_code (cur_code),
    .rd_ptr  (rpos_q),
    .rd_data (out_data),
    .rd_code (out_type)
  );

  dn_pe_select u_select (
    .clk    (clk),
    .rst_n  (rst_n),
    .decide (decide),
    .half   (fifo_half),
    .target (target)
  );

  assign in_ready = (state_q == ST_GATHER);
  assign accept   = in_ready && in_valid;
  assign closing  = in_last || (wpos_q == PTR_W'(DEPTH - 1));
  assign keep     = add_q || cur_add;
  assign decide   = (state_q == ST_ASSIGN);
  assign emit     = (state_q == ST_EMIT) && !fifo_full[target];
  assign out_last = (rpos_q == end_q);
  assign out_nidx = nidx_q;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_push
    assign out_push[k] = emit && (target == 1'(k));
  end

  always_comb begin
    state_d = state_q;
    wpos_d  = wpos_q;
    rpos_d  = rpos_q;
    end_d   = end_q;
    add_d   = add_q;
    nidx_d  = nidx_q;
    unique case (state_q)
      ST_GATHER: begin
        if (accept) begin
          nidx_d = in_nidx;
          if (closing) begin
            end_d  = wpos_q;
            wpos_d = '0;
            rpos_d = '0;
            add_d  = 1'b0;
            if (keep) state_d = ST_ASSIGN;
          end else begin
            wpos_d = wpos_q + 1'b1;
            add_d  = keep;
          end
        end
      end
      ST_ASSIGN: state_d = ST_EMIT;
      ST_EMIT: begin
        if (emit) begin
          if (out_last) state_d = ST_GATHER;
          else          rpos_d  = rpos_q + 1'b1;
        end
      end
      default: state_d = ST_GATHER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GATHER;
      wpos_q  <= '0;
      rpos_q  <= '0;
      end_q   <= '0;
      add_q   <= 1'b0;
      nidx_q  <= '0;
    end else begin
      state_q <= state_d;
      wpos_q  <= wpos_d;
      rpos_q  <= rpos_d;
      end_q   <= end_d;
      add_q   <= add_d;
      nidx_q  <= nidx_d;
    end
  end
endmodule

// File: rtl/dn_checker.sv
module dn_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] fifo_full,
  input logic [1:0] out_push,
  input logic       out_last
);
  a_r1_no_push_full_pe0: assert property (@(posedge clk) disable iff (!rst_n)
    out_push[0] |-> !fifo_full[0]);
  a_r1_no_push_full_pe1: assert property (@(posedge clk) disable iff (!rst_n)
    out_push[1] |-> !fifo_full[1]);
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_push));
  a_r2_stay_pe0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push[0] && !out_last) |=> !out_push[1]);
  a_r2_stay_pe1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push[1] && !out_last) |=> !out_push[0]);
  a_r8_no_push_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push != 2'b00) |-> !in_ready);
  a_r6_quiet_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_push == 2'b00));
endmodule

bind neuron_dispatcher dn_checker u_dn_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .fifo_full (fifo_full),
  .out_push  (out_push),
  .out_last  (out_last)
);

// File: tb/tb_neuron_dispatcher.sv
module tb_neuron_dispatcher;
  localparam int DATA_W = 16;
  localparam int NIDX_W = 12;
  localparam int LAYERS = 4;
  localparam int DEPTH  = 8;

  logic clk, rst_n;
  logic [LAYERS*DEPTH*2-1:0] type_prog;
  logic in_valid, in_ready, in_last;
  logic [NIDX_W-1:0] in_nidx;
  logic [1:0] in_layer;
  logic [DATA_W-1:0] in_data;
  logic [1:0] fifo_half, fifo_full, out_push, out_type;
  logic [NIDX_W-1:0] out_nidx;
  logic [DATA_W-1:0] out_data;
  logic out_last;

  neuron_dispatcher #(.DATA_W(DATA_W), .NIDX_W(NIDX_W), .LAYERS(LAYERS), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .type_prog(type_prog),
    .in_valid(in_valid), .in_ready(in_ready), .in_nidx(in_nidx),
    .in_layer(in_layer), .in_data(in_data), .in_last(in_last),
    .fifo_half(fifo_half), .fifo_full(fifo_full), .out_push(out_push),
    .out_nidx(out_nidx), .out_data(out_data), .out_type(out_type), .out_last(out_last));

  int checks = 0;
  int fails  = 0;
  bit alt_model = 1'b0;
  bit full_rand = 1'b0;
  bit done = 1'b0;

  logic [DATA_W-1:0] got_data [2][DEPTH];
  logic [1:0]        got_type [2][DEPTH];
  logic              got_last [2][DEPTH];
  logic [NIDX_W-1:0] got_nidx [2][DEPTH];
  int                got_cnt  [2];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(input int layer, input int pos);
    return type_prog[(layer*DEPTH+pos)*2 +: 2];
  endfunction

  function automatic int pick_pe(input logic [1:0] half);
    int s;
    if (half[0] != half[1]) s = half[0] ? 1 : 0;
    else begin
      s = alt_model;
      alt_model = ~alt_model;
    end
    return s;
  endfunction

  // push monitor, samples half a cycle away from the active edge
  always @(negedge clk) begin
    #1;
    for (int k = 0; k < 2; k++) begin
      if (rst_n && out_push[k]) begin
        check(!fifo_full[k], "R1 push while full", 1, 0);
        if (got_cnt[k] < DEPTH) begin
          got_data[k][got_cnt[k]] = out_data;
          got_type[k][got_cnt[k]] = out_type;
          got_last[k][got_cnt[k]] = out_last;
          got_nidx[k][got_cnt[k]] = out_nidx;
        end
        got_cnt[k]++;
      end
    end
  end

  // random back-pressure
  always @(negedge clk) begin
    if (full_rand) fifo_full <= {($urandom % 3) == 0, ($urandom % 3) == 0};
    else           fifo_full <= 2'b00;
  end

  task automatic run_neuron(input int layer, input int len, input bit mark, input logic [1:0] half);
    logic [DATA_W-1:0] d [DEPTH];
    logic [NIDX_W-1:0] nid;
    bit keep;
    int sel, waitc;
    @(negedge clk);
    got_cnt[0] = 0;
    got_cnt[1] = 0;
    fifo_half = half;
    nid = NIDX_W'($urandom);
    keep = 1'b0;
    for (int i = 0; i < len; i++) begin
      d[i] = DATA_W'($urandom);
      if (code_of(layer, i) == 2'b00) keep = 1'b1;
    end
    sel = keep ? pick_pe(half) : -1;
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      in_valid = 1'b1;
      in_layer = 2'(layer);
      in_nidx  = nid;
      in_data  = d[i];
      in_last  = mark && (i == len - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    #1;
    if (keep) check(!in_ready, "R8 ready low after kept neuron closes", in_ready, 0);
    else      check(in_ready, "R6 ready right after pruned neuron", in_ready, 1);
    waitc = 0;
    while (!in_ready && waitc < 2000) begin
      @(negedge clk);
      #1;
      waitc++;
    end
    @(negedge clk);
    #2;
    if (!keep) begin
      check(got_cnt[0] + got_cnt[1] == 0, "R6 pruned neuron pushes nothing", got_cnt[0] + got_cnt[1], 0);
    end else begin
      check(got_cnt[sel] == len, "R7 entries on chosen element", got_cnt[sel], len);
      check(got_cnt[1-sel] == 0, "R3 R4 nothing on other element", got_cnt[1-sel], 0);
      if (got_cnt[sel] == len) begin
        for (int i = 0; i < len; i++) begin
          check(got_data[sel][i] == d[i], "R2 data order", got_data[sel][i], d[i]);
          check(got_nidx[sel][i] == nid, "R2 neuron index", got_nidx[sel][i], nid);
          check(got_type[sel][i] == code_of(layer, i), "R5 type code", got_type[sel][i], code_of(layer, i));
          check(got_last[sel][i] == (i == len - 1), "R2 last marker", got_last[sel][i], i == len - 1);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_nidx = '0;
    in_layer = '0; in_data = '0; fifo_half = 2'b00;
    got_cnt[0] = 0; got_cnt[1] = 0;
    for (int i = 0; i < LAYERS*DEPTH; i++) type_prog[i*2 +: 2] = 2'($urandom);
    type_prog[1:0] = 2'b00;                         // layer 0 position 0 additive
    for (int i = 0; i < DEPTH; i++) type_prog[(3*DEPTH+i)*2 +: 2] = 2'b01 + 2'(i % 2); // layer 3 never additive
    type_prog[(2*DEPTH+1)*2 +: 2] = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R9 reset ready", in_ready, 1);
    check(out_push == 2'b00, "R9 reset no push", out_push, 0);
    rst_n = 1'b1;
    // R4 ties from reset: element 0 then element 1
    run_neuron(0, 3, 1, 2'b00);
    run_neuron(0, 2, 1, 2'b11);
    // R3 one loaded element
    run_neuron(0, 4, 1, 2'b01);
    run_neuron(0, 1, 1, 2'b10);
    // R6 pruned neuron
    run_neuron(3, 5, 1, 2'b00);
    // R7 closed by depth without marker, then a follow-on neuron
    run_neuron(0, DEPTH, 0, 2'b00);
    run_neuron(0, 2, 1, 2'b00);
    // R1 random back-pressure and mixed traffic
    full_rand = 1'b1;
    for (int n = 0; n < 120; n++) begin
      int len;
      len = 1 + int'($urandom % DEPTH);
      run_neuron(int'($urandom % LAYERS), len, (len == DEPTH) ? bit'($urandom) : 1'b1, 2'($urandom));
    end
    full_rand = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule